// File: doc/BRIEF.md
# Port Code Converter with Range Flags

This block takes one straight-binary sample per output port, together with that sample's raw above-range and below-range indications. It produces the final port code and a pair of registered range flags for each port. Three lanes sit side by side. Each lane has its own coding select, which picks plain binary or two's complement. A shared format input tells the lanes when the 4:2:2 format is active. In that format, binary-coded ports must never emit the all-zeros or all-ones words, because downstream equipment reserves them for synchronization.

The three samples of a beat arrive together on a single valid/ready input stream and leave together on a single valid/ready output stream. The stage is one register deep. The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no new beat is taken. The format and coding selects are plain control pins and are sampled at the beat's acceptance.

Top module: `outcode_conv`

## Requirements
- R1: A synchronous reset clears `out_valid`, drives every output code to 0x00 and clears every overflow and underflow flag.
- R2: With the format input low, coding select 0 (binary) and no range indication, a lane outputs its input code unchanged.
- R3: Coding select 1 outputs the binary code with bit 7 inverted (binary 0x00 becomes 0x80, 0xFF becomes 0x7F). Each lane follows only its own select bit, whatever the format input.
- R4: A raw above-range indication sets that lane's overflow flag and saturates the code to the top value: 0xFF in binary and 0x7F in two's complement.
- R5: A raw below-range indication sets that lane's underflow flag and saturates the code to the bottom value: 0x00 in binary and 0x80 in two's complement.
- R6: The two flags of a lane are never both 1. When both raw indications are present, overflow wins and the underflow flag stays 0.
- R7: With the format input high and binary coding, code 0x00 is output as 0x01 and 0xFF as 0xFE, saturated codes included. Codes 0x01 to 0xFE pass unchanged.
- R8: With the format input high and two's complement coding, no clipping applies: 0x00 gives 0x80 and 0xFF gives 0x7F.
- R9: A beat accepted at a clock edge appears on the outputs with `out_valid` high right after that edge, which is one cycle of latency.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output codes and flags stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_422 | input | 1 | High when the 4:2:2 format is active |
| twos_sel | input | 3 | Per-lane coding select, 1 = two's complement |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_code | input | 24 | Binary codes, lane i in bits 8i+7..8i |
| in_over | input | 3 | Raw above-range indication per lane |
| in_under | input | 3 | Raw below-range indication per lane |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_code | output | 24 | Port codes, lane i in bits 8i+7..8i |
| out_ovf | output | 3 | Registered overflow flag per lane |
| out_unf | output | 3 | Registered underflow flag per lane |

## Verification
Mid-scale codes, run with three different coding selects across the lanes, separate lanes that ignore their neighbours' selects from lanes that share a select. The extreme codes 0x00 and 0xFF, plus the saturated codes from range indications, are applied with the format input both low and high. This shows where clipping applies and where it must not. Near-extreme codes 0x01 and 0xFE confirm that clipping affects only the two reserved words. Holding `out_ready` low while a second beat waits shows whether the stage stalls or overwrites.

// File: rtl/outcode_pkg.sv
package outcode_pkg;
  typedef enum logic {
    CODE_BIN  = 1'b0,
    CODE_TWOS = 1'b1
  } code_mode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
  } range_flags_t;
endpackage

// File: rtl/outcode_sat.sv
module outcode_sat #(
  parameter int W = 8
) (
  input  logic [W-1:0]               raw,
  input  logic                       over,
  input  logic                       under,
  output logic [W-1:0]               sat,
  output outcode_pkg::range_flags_t  flags
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = {W{1'b0}};

  always_comb begin
    flags.ovf = over;
    flags.unf = under && !over;
    if (over)       sat = TOP;
    else if (under) sat = BOT;
    else            sat = raw;
  end
endmodule

// File: rtl/outcode_map.sv
module outcode_map #(
  parameter int W = 8
) (
  input  logic [W-1:0]            sat,
  input  logic                    clip_en,
  input  outcode_pkg::code_mode_e mode,
  output logic [W-1:0]            code
);
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] BOT  = {W{1'b0}};
  localparam logic [W-1:0] MSB1 = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] clipped;

  always_comb begin
    clipped = sat;
    if (clip_en) begin
      if (sat == BOT)      clipped = BOT + 1'b1;
      else if (sat == TOP) clipped = TOP - 1'b1;
    end
    code = (mode == outcode_pkg::CODE_TWOS) ? (clipped ^ MSB1) : clipped;
  end
endmodule

// File: rtl/outcode_lane.sv
module outcode_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         fmt_422,
  input  logic         twos,
  input  logic [W-1:0] raw,
  input  logic         over,
  input  logic         under,
  output logic [W-1:0] code_q,
  output logic         ovf_q,
  output logic         unf_q
);
  import outcode_pkg::*;

  logic [W-1:0] sat;
  logic [W-1:0] code_d;
  range_flags_t flags;
  code_mode_e   mode;

  assign mode = twos ? CODE_TWOS : CODE_BIN;

  outcode_sat #(.W(W)) u_sat (
    .raw   (raw),
    .over  (over),
    .under (under),
    .sat   (sat),
    .flags (flags)
  );

  outcode_map #(.W(W)) u_map (
    .sat     (sat),
    .clip_en (fmt_422 && !twos),
    .mode    (mode),
    .code    (code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else if (load) begin
      code_q <= code_d;
      ovf_q  <= flags.ovf;
      unf_q  <= flags.unf;
    end
  end
endmodule

// File: rtl/outcode_conv.sv
module outcode_conv #(
  parameter int LANES = 3,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fmt_422,
  input  logic [LANES-1:0]   twos_sel,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LANES*W-1:0] in_code,
  input  logic [LANES-1:0]   in_over,
  input  logic [LANES-1:0]   in_under,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LANES*W-1:0] out_code,
  output logic [LANES-1:0]   out_ovf,
  output logic [LANES-1:0]   out_unf
);
  logic vld_q;
  logic take;

  assign in_ready  = !vld_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = vld_q;

  always_ff @(posedge clk) begin
    if (rst)            vld_q <= 1'b0;
    else if (take)      vld_q <= 1'b1;
    else if (out_ready) vld_q <= 1'b0;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    outcode_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .load    (take),
      .fmt_422 (fmt_422),
      .twos    (twos_sel[i]),
      .raw     (in_code[i*W +: W]),
      .over    (in_over[i]),
      .under   (in_under[i]),
      .code_q  (out_code[i*W +: W]),
      .ovf_q   (out_ovf[i]),
      .unf_q   (out_unf[i])
    );
  end
endmodule

// File: rtl/outcode_conv_chk.sv
module outcode_conv_chk #(
  parameter int LANES = 3,
  parameter int W     = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               fmt_422,
  input logic [LANES-1:0]   twos_sel,
  input logic               in_valid,
  input logic               in_ready,
  input logic [LANES-1:0]   in_over,
  input logic [LANES-1:0]   in_under,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LANES*W-1:0] out_code,
  input logic [LANES-1:0]   out_ovf,
  input logic [LANES-1:0]   out_unf
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> !out_valid && out_code == '0 && out_ovf == '0 && out_unf == '0); // R1

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) (out_ovf & out_unf) == '0); // R6

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) in_valid && in_ready |=> out_valid); // R9

  AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (rst) out_valid && !out_ready |-> !in_ready); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_ovf) && $stable(out_unf)); // R10

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    AST_OVF_TOP_BIN: assert property (@(posedge clk) disable iff (rst) in_valid && in_ready && in_over[i] && !fmt_422 && !twos_sel[i] |=> out_code[i*W +: W] == {W{1'b1}} && out_ovf[i]); // R4

    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst) in_valid && in_ready && fmt_422 && !twos_sel[i] |=> out_code[i*W +: W] != {W{1'b0}} && out_code[i*W +: W] != {W{1'b1}}); // R7
  end
endmodule

bind outcode_conv outcode_conv_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fmt_422   (fmt_422),
  .twos_sel  (twos_sel),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_over   (in_over),
  .in_under  (in_under),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_code  (out_code),
  .out_ovf   (out_ovf),
  .out_unf   (out_unf)
);

// File: tb/outcode_conv_tb.sv
module outcode_conv_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        fmt_422;
  logic [2:0]  twos_sel;
  logic        in_valid;
  logic        in_ready;
  logic [23:0] in_code;
  logic [2:0]  in_over;
  logic [2:0]  in_under;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_code;
  logic [2:0]  out_ovf;
  logic [2:0]  out_unf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  outcode_conv u_dut (
    .clk(clk), .rst(rst), .fmt_422(fmt_422), .twos_sel(twos_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
    .in_over(in_over), .in_under(in_under), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .out_ovf(out_ovf),
    .out_unf(out_unf)
  );

  function automatic logic [7:0] expect_code(logic [7:0] raw, logic ov, logic un, logic f, logic tw);
    logic [7:0] v;
    v = ov ? 8'hFF : (un ? 8'h00 : raw);
    if (f && !tw) begin
      if (v == 8'h00) v = 8'h01;
      else if (v == 8'hFF) v = 8'hFE;
    end
    if (tw) v = {~v[7], v[6:0]};
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Offer one beat with out_ready high, then check every lane one cycle later.
  task automatic beat(string tag, logic [23:0] c, logic [2:0] ov, logic [2:0] un);
    @(negedge clk);
    in_code = c; in_over = ov; in_under = un; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      check({tag, " code"}, {24'd0, out_code[i*8 +: 8]},
            {24'd0, expect_code(c[i*8 +: 8], ov[i], un[i], fmt_422, twos_sel[i])});
      check({tag, " ovf"}, {31'd0, out_ovf[i]}, {31'd0, ov[i]});
      check({tag, " unf"}, {31'd0, out_unf[i]}, {31'd0, un[i] & ~ov[i]});
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 code", {8'd0, out_code}, 32'd0);
    check("R1 flags", {26'd0, out_ovf, out_unf}, 32'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_binary;
    fmt_422 = 0; twos_sel = 3'b000;
    beat("R2 mid", 24'h5A_3C_81, 3'b000, 3'b000);
    beat("R2 ends", 24'hFF_00_7F, 3'b000, 3'b000);
  endtask

  task automatic t_twos;
    fmt_422 = 0; twos_sel = 3'b101;
    beat("R3 mixed", 24'h00_FF_40, 3'b000, 3'b000);
    twos_sel = 3'b010;
    beat("R3 mixed2", 24'hFF_00_C3, 3'b000, 3'b000);
    fmt_422 = 1; twos_sel = 3'b111;
    beat("R3 fmt", 24'h12_34_56, 3'b000, 3'b000);
  endtask

  task automatic t_over_under;
    fmt_422 = 0; twos_sel = 3'b010;
    beat("R4 over", 24'h10_20_30, 3'b111, 3'b000);
    beat("R5 under", 24'h90_A0_B0, 3'b000, 3'b111);
    beat("R6 both", 24'h44_55_66, 3'b011, 3'b110);
  endtask

  task automatic t_422;
    fmt_422 = 1; twos_sel = 3'b000;
    beat("R7 clip", 24'h00_FF_01, 3'b000, 3'b000);
    beat("R7 keep", 24'hFE_80_7F, 3'b000, 3'b000);
    beat("R7 sat", 24'h33_33_33, 3'b001, 3'b010);
    twos_sel = 3'b111;
    beat("R8 noclip", 24'h00_FF_00, 3'b000, 3'b000);
  endtask

  task automatic t_backpressure;
    fmt_422 = 0; twos_sel = 3'b000;
    @(negedge clk);
    out_ready = 1'b0;
    in_code = 24'h11_22_33; in_over = 0; in_under = 0; in_valid = 1'b1;
    @(posedge clk); #1;
    check("R9 first", {8'd0, out_code}, 32'h112233);
    @(negedge clk);
    in_code = 24'hAA_BB_CC;
    #1;
    check("R10 ready low", {31'd0, in_ready}, 32'd0);
    @(posedge clk); #1;
    check("R10 hold", {8'd0, out_code}, 32'h112233);
    check("R10 valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check("R10 ready high", {31'd0, in_ready}, 32'd1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check("R9 second", {8'd0, out_code}, 32'hAABBCC);
    @(posedge clk); #1;
    check("R9 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    rst = 1'b1; fmt_422 = 0; twos_sel = 0; in_valid = 0;
    in_code = 0; in_over = 0; in_under = 0; out_ready = 1'b1;
    t_reset();
    t_binary();
    t_twos();
    t_over_under();
    t_422();
    t_backpressure();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule